// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Corrector

This block applies the error reports produced by a Reed-Solomon decoder to a 512-byte sector that sits in a byte-wide buffer RAM. The decoder works on 9-bit symbols packed back to back into the byte stream. A symbol can straddle a byte boundary, so every fix is a read-modify-write over two neighbouring bytes. The decoder's status word and up to four report words are presented together with a start pulse. The block latches them, walks the reports in order and drives the buffer port itself.

For a report with 0-based symbol index i, the corrector reads the bytes at addresses i + (i >> 3) and the one after it. It treats the two bytes as a little-endian 16-bit window and flips the masked bits of the 9-bit field at offset i & 7. It then writes both bytes back. When the walk ends it pulses done, together with the number of corrections applied and an uncorrectable flag.

Top module: `rs_symbol_fixer`

## Requirements
- R1: A start pulse is accepted only while the block is idle and the status word has its decode-finished bit (bit 3) set. A start whose status has bit 3 clear leaves the block idle, with no buffer access and no done pulse.
- R2: If the status error flag (bit 0) is clear, the block makes no buffer access and finishes with a correction count of 0 and the uncorrectable flag low.
- R3: If bit 0 and the uncorrectable flag (bit 1) are both set, the block makes no buffer access and finishes with the uncorrectable flag high and a count of 0.
- R4: The report count is taken from status bits 31:29 and limited to 4. Reports are handled strictly in order from report 0 up to count-1, and each report first takes one scan cycle.
- R5: Each report word carries a 1-based symbol index in bits 24:16 and a 9-bit mask in bits 8:0. If the index minus one is not in the range 0..511 (an index field of 0, for example), the report is skipped. A skipped report makes no buffer access and is not counted.
- R6: For i = index-1, the low byte address is i + (i >> 3) and the high byte is the next address. The bit offset inside the 16-bit window is i & 7.
- R7: A report that is applied drives four consecutive cycles on the buffer port: read low byte, read high byte, write low byte, write high byte. The buffer returns read data one cycle after the read.
- R8: The nine window bits starting at the bit offset are XORed with the mask. All other bits of both bytes are written back unchanged.
- R9: Busy is high from the cycle after an accepted start until the end of a one-cycle done pulse. The done pulse follows the last scan or write cycle. Along with done, the count output gives the number of reports applied and the uncorrectable output gives the outcome.
- R10: A start pulse that arrives while the block is busy is ignored. The status and reports latched at the accepted start stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse |
| statusIn | input | 32 | Decoder status word |
| reportsIn | input | 128 | Four report words, report r at bits r*32+31:r*32 |
| bufRdData | input | 8 | Buffer read data, one cycle after bufRdEn |
| bufAddr | output | 10 | Buffer byte address |
| bufRdEn | output | 1 | Buffer read strobe |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrData | output | 8 | Buffer write data |
| busyOut | output | 1 | Block is processing a sector |
| donePulse | output | 1 | One-cycle completion pulse |
| fixCount | output | 3 | Corrections applied in the last run |
| uncorrOut | output | 1 | Last run was uncorrectable |

## Verification
The assertions assume that the buffer answers every read with data on the next cycle and that nothing else writes the buffer while the block is busy. They also assume that statusIn and reportsIn hold the intended values in the cycle the start pulse is sampled. The stimulus meets these assumptions: the bench owns the only buffer model, which has a fixed one-cycle read latency, and it changes status and reports only at the falling edge on which it raises start. The exception is the busy-start case, where the bench deliberately presents altered words to show that they are ignored.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_RD0, S_RD1, S_WR0, S_WR1, S_DONE
  } fixPhase_t;

  typedef struct packed {
    logic load;
    logic nextRpt;
    logic capLo;
    logic capHi;
    logic bumpFix;
    logic useHi;
  } fixStrobe_t;

endpackage

// File: rtl/rsfix_dp.sv
module rsfix_dp
  import rsfix_pkg::*;
#(
  parameter int MAX_REPORTS  = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int SYM_W        = 9,
  localparam int FIELD_W = 9,
  localparam int WIN_W   = 16,
  localparam int ADDR_W  = $clog2(SECTOR_BYTES + SECTOR_BYTES / 8),
  localparam int CNT_W   = $clog2(MAX_REPORTS + 1),
  localparam int PTR_W   = $clog2(MAX_REPORTS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fixStrobe_t              st,
  input  logic                    statusErr,
  input  logic                    statusUnc,
  input  logic [2:0]              statusCnt,
  input  logic [MAX_REPORTS*32-1:0] reportsIn,
  input  logic [7:0]              bufRdData,
  output logic [ADDR_W-1:0]       bufAddr,
  output logic [7:0]              bufWrData,
  output logic                    noWork,
  output logic                    rptValid,
  output logic                    lastRpt,
  output logic [CNT_W-1:0]        fixCount,
  output logic                    uncorr
);

  logic [FIELD_W-1:0] idxQ  [MAX_REPORTS];
  logic [SYM_W-1:0]   maskQ [MAX_REPORTS];
  logic [MAX_REPORTS-1:0] unusedRpt;

  logic             errQ, uncQ;
  logic [CNT_W-1:0] cntQ, cntClamp, fixQ;
  logic [PTR_W-1:0] ptrQ;
  logic [7:0]       loQ, hiQ;

  logic [FIELD_W:0]    symIdx;
  logic [ADDR_W-1:0]   baseAddr;
  logic [2:0]          bitOff;
  logic [WIN_W-1:0]    shifted;

  // latch the fields of every report word at start
  for (genvar g = 0; g < MAX_REPORTS; g++) begin : g_rpt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxQ[g]  <= '0;
        maskQ[g] <= '0;
      end else if (st.load) begin
        idxQ[g]  <= reportsIn[g*32+16 +: FIELD_W];
        maskQ[g] <= reportsIn[g*32 +: SYM_W];
      end
    end
    assign unusedRpt[g] = ^{reportsIn[g*32+25 +: 7], reportsIn[g*32+SYM_W +: 16-SYM_W]};
  end

  assign cntClamp = (int'(statusCnt) > MAX_REPORTS) ? CNT_W'(MAX_REPORTS) : CNT_W'(statusCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
      uncQ <= 1'b0;
      cntQ <= '0;
      ptrQ <= '0;
      fixQ <= '0;
      loQ  <= '0;
      hiQ  <= '0;
    end else begin
      if (st.load) begin
        errQ <= statusErr;
        uncQ <= statusErr & statusUnc;
        cntQ <= cntClamp;
        ptrQ <= '0;
        fixQ <= '0;
      end
      if (st.nextRpt) ptrQ <= ptrQ + 1'b1;
      if (st.capLo)   loQ  <= bufRdData;
      if (st.capHi)   hiQ  <= bufRdData;
      if (st.bumpFix) fixQ <= fixQ + 1'b1;
    end
  end

  // 1-based index to 0-based; a zero field wraps high and fails the range test
  assign symIdx   = {1'b0, idxQ[ptrQ]} - 1'b1;
  assign rptValid = int'(symIdx) < SECTOR_BYTES;
  assign baseAddr = ADDR_W'(symIdx + (symIdx >> 3));
  assign bitOff   = symIdx[2:0];
  assign shifted  = {{(WIN_W-SYM_W){1'b0}}, maskQ[ptrQ]} << bitOff;

  assign bufAddr   = baseAddr + ADDR_W'(st.useHi);
  assign bufWrData = st.useHi ? (hiQ ^ shifted[15:8]) : (loQ ^ shifted[7:0]);

  assign noWork   = !errQ || uncQ || (cntQ == '0);
  assign lastRpt  = (CNT_W'(ptrQ) + CNT_W'(1)) == cntQ;
  assign fixCount = fixQ;
  assign uncorr   = uncQ;

  p_fix_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(fixQ) <= int'(cntQ));

  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.nextRpt |-> !lastRpt);

endmodule

// File: rtl/rsfix_ctrl.sv
module rsfix_ctrl
  import rsfix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       decodeDone,
  input  logic       noWork,
  input  logic       rptValid,
  input  logic       lastRpt,
  output fixStrobe_t st,
  output logic       rdEn,
  output logic       wrEn,
  output logic       busy,
  output logic       donePulse
);

  fixPhase_t phaseQ, phaseD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= S_IDLE;
    else       phaseQ <= phaseD;
  end

  always_comb begin
    phaseD    = phaseQ;
    st        = '0;
    rdEn      = 1'b0;
    wrEn      = 1'b0;
    donePulse = 1'b0;
    unique case (phaseQ)
      S_IDLE: if (startIn && decodeDone) begin
        st.load = 1'b1;
        phaseD  = S_SCAN;
      end
      S_SCAN: begin
        if (noWork)        phaseD = S_DONE;
        else if (rptValid) phaseD = S_RD0;
        else if (lastRpt)  phaseD = S_DONE;
        else               st.nextRpt = 1'b1;
      end
      S_RD0: begin
        rdEn   = 1'b1;
        phaseD = S_RD1;
      end
      S_RD1: begin
        rdEn     = 1'b1;
        st.useHi = 1'b1;
        st.capLo = 1'b1;
        phaseD   = S_WR0;
      end
      S_WR0: begin
        wrEn     = 1'b1;
        st.capHi = 1'b1;
        phaseD   = S_WR1;
      end
      S_WR1: begin
        wrEn       = 1'b1;
        st.useHi   = 1'b1;
        st.bumpFix = 1'b1;
        if (lastRpt) phaseD = S_DONE;
        else begin
          st.nextRpt = 1'b1;
          phaseD     = S_SCAN;
        end
      end
      S_DONE: begin
        donePulse = 1'b1;
        phaseD    = S_IDLE;
      end
      default: phaseD = S_IDLE;
    endcase
  end

  assign busy = phaseQ != S_IDLE;

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));

  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !$past(wrEn)) |-> $past(rdEn));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !busy);

endmodule

// File: rtl/rs_symbol_fixer.sv
module rs_symbol_fixer
  import rsfix_pkg::*;
#(
  parameter int MAX_REPORTS  = 4,
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = $clog2(SECTOR_BYTES + SECTOR_BYTES / 8),
  localparam int CNT_W  = $clog2(MAX_REPORTS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startIn,
  input  logic [31:0]               statusIn,
  input  logic [MAX_REPORTS*32-1:0] reportsIn,
  input  logic [7:0]                bufRdData,
  output logic [ADDR_W-1:0]         bufAddr,
  output logic                      bufRdEn,
  output logic                      bufWrEn,
  output logic [7:0]                bufWrData,
  output logic                      busyOut,
  output logic                      donePulse,
  output logic [CNT_W-1:0]          fixCount,
  output logic                      uncorrOut
);

  fixStrobe_t strobe;
  logic noWork, rptValid, lastRpt;
  logic unusedStatus;

  assign unusedStatus = ^{statusIn[28:4], statusIn[2]};

  rsfix_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .decodeDone(statusIn[3]),
    .noWork    (noWork),
    .rptValid  (rptValid),
    .lastRpt   (lastRpt),
    .st        (strobe),
    .rdEn      (bufRdEn),
    .wrEn      (bufWrEn),
    .busy      (busyOut),
    .donePulse (donePulse)
  );

  rsfix_dp #(
    .MAX_REPORTS (MAX_REPORTS),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobe),
    .statusErr(statusIn[0]),
    .statusUnc(statusIn[1]),
    .statusCnt(statusIn[31:29]),
    .reportsIn(reportsIn),
    .bufRdData(bufRdData),
    .bufAddr  (bufAddr),
    .bufWrData(bufWrData),
    .noWork   (noWork),
    .rptValid (rptValid),
    .lastRpt  (lastRpt),
    .fixCount (fixCount),
    .uncorr   (uncorrOut)
  );

  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bufRdEn || bufWrEn) |-> (int'(bufAddr) < SECTOR_BYTES + SECTOR_BYTES / 8));

  p_uncorr_nofix_r3: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && uncorrOut) |-> (fixCount == '0));

  p_busy_latched_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !donePulse) |=> $stable(uncorrOut));

  p_fix_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(fixCount) <= MAX_REPORTS);

endmodule

// File: tb/rs_symbol_fixer_tb_top.sv
`timescale 1ns/1ps
module rs_symbol_fixer_tb_top;

  localparam int MEM_BYTES = 576;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [31:0]  statusIn = '0;
  logic [127:0] reportsIn = '0;
  logic [7:0]   bufRdData;
  logic [9:0]   bufAddr;
  logic         bufRdEn, bufWrEn;
  logic [7:0]   bufWrData;
  logic         busyOut, donePulse;
  logic [2:0]   fixCount;
  logic         uncorrOut;

  always #10 clk = ~clk;

  rs_symbol_fixer dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .statusIn(statusIn),
    .reportsIn(reportsIn), .bufRdData(bufRdData), .bufAddr(bufAddr),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .busyOut(busyOut), .donePulse(donePulse), .fixCount(fixCount),
    .uncorrOut(uncorrOut)
  );

  // buffer RAM with one-cycle read latency
  logic [7:0] mem [MEM_BYTES];
  always_ff @(posedge clk) begin
    if (bufWrEn) mem[bufAddr] <= bufWrData;
    if (bufRdEn) bufRdData <= mem[bufAddr];
  end

  typedef struct {
    bit    busy, rd, wr, done, unc;
    int    addr, wdata, cnt;
    string tag;
  } expEntry_t;

  expEntry_t expQ[$];
  int shadow [MEM_BYTES];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic void push(bit rd, bit wr, bit done, int addr, int wdata,
                               int cnt, bit unc, string tag);
    expEntry_t e;
    e.busy = 1; e.rd = rd; e.wr = wr; e.done = done; e.addr = addr;
    e.wdata = wdata; e.cnt = cnt; e.unc = unc; e.tag = tag;
    expQ.push_back(e);
  endfunction

  // behavioural model: expected bus activity per cycle after an accepted start
  function automatic void buildModel(logic [31:0] st, logic [31:0] rp [4], string doneTag);
    bit err, unc;
    int n, fixes;
    expQ.delete();
    if (!st[3]) return;
    err = st[0];
    unc = st[0] && st[1];
    n = int'(st[31:29]);
    if (n > 4) n = 4;
    push(0, 0, 0, 0, 0, 0, 0, "R4");
    if (!err || unc || n == 0) begin
      push(0, 0, 1, 0, 0, 0, unc, doneTag);
      return;
    end
    fixes = 0;
    for (int r = 0; r < n; r++) begin
      int field, mask, i, a, off, w;
      if (r > 0) push(0, 0, 0, 0, 0, 0, 0, "R4");
      field = int'(rp[r][24:16]);
      mask  = int'(rp[r][8:0]);
      if (field == 0 || field - 1 >= 512) continue;
      i = field - 1;
      a = i + (i >> 3);
      off = i & 7;
      w = shadow[a] | (shadow[a+1] << 8);
      w = w ^ (mask << off);
      push(1, 0, 0, a, 0, 0, 0, "R6");
      push(1, 0, 0, a + 1, 0, 0, 0, "R7");
      push(0, 1, 0, a, w & 255, 0, 0, "R8");
      push(0, 1, 0, a + 1, (w >> 8) & 255, 0, 0, "R8");
      shadow[a] = w & 255;
      shadow[a+1] = (w >> 8) & 255;
      fixes++;
    end
    push(0, 0, 1, 0, 0, fixes, 0, doneTag);
  endfunction

  task automatic cmpEntry(expEntry_t e);
    chk(busyOut == e.busy, e.tag, "busy", busyOut, e.busy);
    chk(bufRdEn == e.rd, e.tag, "rdEn", bufRdEn, e.rd);
    chk(bufWrEn == e.wr, e.tag, "wrEn", bufWrEn, e.wr);
    chk(donePulse == e.done, e.tag, "done", donePulse, e.done);
    if (e.rd || e.wr) chk(int'(bufAddr) == e.addr, e.tag, "addr", bufAddr, e.addr);
    if (e.wr) chk(int'(bufWrData) == e.wdata, e.tag, "wdata", bufWrData, e.wdata);
    if (e.done) begin
      chk(int'(fixCount) == e.cnt, e.tag, "count", fixCount, e.cnt);
      chk(uncorrOut == e.unc, e.tag, "uncorr", uncorrOut, e.unc);
    end
  endtask

  task automatic idleChk(int n, string tag);
    repeat (n) begin
      @(negedge clk);
      chk(!busyOut, tag, "idle busy", busyOut, 0);
      chk(!bufRdEn && !bufWrEn, tag, "idle access", {bufRdEn, bufWrEn}, 0);
      chk(!donePulse, tag, "idle done", donePulse, 0);
    end
  endtask

  function automatic logic [31:0] mkRep(int field, int mask);
    return (32'(field) << 16) | 32'(mask);
  endfunction

  task automatic runCase(logic [31:0] st, logic [31:0] rp [4], string tag, bit inject);
    buildModel(st, rp, tag);
    @(negedge clk);
    statusIn  = st;
    reportsIn = {rp[3], rp[2], rp[1], rp[0]};
    startIn   = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    foreach (expQ[k]) begin
      if (k > 0) @(negedge clk);
      if (inject && k == 2) begin
        startIn = 1'b0;
        statusIn = {st[31:4], 4'b0000};
        reportsIn = '0;
      end
      cmpEntry(expQ[k]);
      if (inject && k == 1) begin
        // R10: start during busy with altered words
        startIn   = 1'b1;
        statusIn  = 32'h2000_000B;
        reportsIn = {4{mkRep(3, 9'h1FF)}};
      end
    end
    startIn = 1'b0;
    idleChk(2, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rp [4];
    for (int k = 0; k < MEM_BYTES; k++) begin
      mem[k] = 8'((k * 37 + 11) & 255);
      shadow[k] = (k * 37 + 11) & 255;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busyOut && !donePulse, "R9", "reset busy/done", {busyOut, donePulse}, 0);
    chk(fixCount == 0 && !uncorrOut, "R9", "reset count/uncorr", {fixCount, uncorrOut}, 0);
    chk(!bufRdEn && !bufWrEn, "R7", "reset access", {bufRdEn, bufWrEn}, 0);

    // R1: decode-finished clear -> start ignored
    rp[0] = mkRep(5, 9'h0FF); rp[1] = 0; rp[2] = 0; rp[3] = 0;
    @(negedge clk);
    statusIn = 32'h2000_0001;
    reportsIn = {rp[3], rp[2], rp[1], rp[0]};
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chk(!busyOut, "R1", "busy after ignored start", busyOut, 0);
    idleChk(4, "R1");

    // R2: error flag clear
    runCase(32'h6000_0008, rp, "R2", 0);
    // R3: uncorrectable
    runCase(32'h4000_000B, rp, "R3", 0);
    // error flag with zero count
    runCase(32'h0000_0009, rp, "R2", 0);

    // single report, index 1, full mask
    rp[0] = mkRep(1, 9'h1FF);
    runCase(32'h2000_0009, rp, "R8", 0);

    // four reports: offset 7, mid-sector, last reachable symbol
    rp[0] = mkRep(8, 9'h155);
    rp[1] = mkRep(200, 9'h0A3);
    rp[2] = mkRep(511, 9'h1C1);
    rp[3] = mkRep(64, 9'h001);
    runCase(32'h8000_0009, rp, "R6", 0);

    // R5: skipped reports mixed with valid ones
    rp[0] = mkRep(0, 9'h1FF);
    rp[1] = mkRep(33, 9'h07E);
    rp[2] = mkRep(0, 9'h011);
    rp[3] = mkRep(2, 9'h100);
    runCase(32'h8000_0009, rp, "R5", 0);

    // R4: count 7 limited to 4, overlapping neighbours in order
    rp[0] = mkRep(9, 9'h1FF);
    rp[1] = mkRep(10, 9'h1FF);
    rp[2] = mkRep(11, 9'h0F0);
    rp[3] = mkRep(12, 9'h10F);
    runCase(32'hE000_0009, rp, "R4", 0);

    // R10: start while busy ignored
    rp[0] = mkRep(100, 9'h123);
    rp[1] = mkRep(101, 9'h0C3);
    rp[2] = 0; rp[3] = 0;
    runCase(32'h4000_0009, rp, "R10", 1);

    // R7/R8: final buffer contents match the model
    @(negedge clk);
    for (int k = 0; k < MEM_BYTES; k++)
      if (int'(mem[k]) != shadow[k])
        chk(0, "R8", "buffer byte", mem[k], shadow[k]);
    chk(1, "R7", "buffer compare done", 1, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule